// File: doc/BRIEF.md
# UART Host Data Port with Transmit and Receive Queues

This block is the host-side data path of a UART. It sits between a simple register-style bus and the serial transmit and receive engines. A host write places one byte in a transmit queue, and the transmit engine drains that queue through a valid/ready handshake. The receive engine delivers characters, each with a parity-error flag and a framing-error flag. The block stores the character and both flags together in a receive queue. The host reads back one 11-bit word that holds the oldest received character, its two flags and a sticky overrun flag.

With FIFO mode off, each direction keeps exactly one entry: a one-byte transmit holding register and a one-character receive buffer. Changing the mode empties both directions. The overrun flag is not stored with any character. It is set when a character arrives and there is no room for it, and a host read clears it. Four status outputs tell the host whether each queue is full or empty.

Top module: `uart_dataport`

## Requirements
- R1: With FIFO mode on, bytes written by the host reach `tx_data` in write order. `tx_valid` is high while any byte is queued, and a byte leaves the queue on a clock edge where `tx_valid` and `tx_ready` are both high.
- R2: The transmit queue holds 16 bytes. `tx_full` rises on the 16th byte, and a write made while full is dropped.
- R3: The read word `rd_data` carries the data byte in bits 7:0, the framing flag in bit 8, the parity flag in bit 9 and overrun in bit 10. It shows the oldest entry, and a host read (`rd_en`) removes that entry on the clock edge.
- R4: With FIFO mode on, the receive queue holds 16 characters. `rx_full` rises on the 16th character, and `rx_empty` is high only when nothing is stored.
- R5: A character that arrives while the receive side is full is discarded, and the stored entries keep their contents and order. Fullness is judged before a read in the same cycle.
- R6: The overrun flag is set by a character arriving while the receive side is full. It stays set until a host read and is cleared by that read. If an arrival on a full receive side happens in the same cycle as a read, the flag ends up set.
- R7: A read of an empty receive side returns zero in bits 9:0 and removes nothing. The next character stored is the next one read.
- R8: With FIFO mode off, the transmit side holds one byte. `tx_full` is high while that byte waits, and a second write is dropped.
- R9: With FIFO mode off, the receive side holds one character. A second arrival before it is read sets overrun and is discarded.
- R10: A change of `fifo_en` empties both the transmit and receive sides on the next clock edge.
- R11: After reset both sides are empty, `tx_valid` is low, overrun is clear and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | High selects 16-entry queues; low selects single-entry holding |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe; removes the entry shown on rd_data |
| rd_data | output | 11 | Read word: overrun, parity, framing, data |
| tx_valid | output | 1 | A byte is available to the transmit engine |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmit engine takes tx_data |
| rx_valid | input | 1 | Receive engine delivers a character |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for this character |
| rx_ferr | input | 1 | Framing error for this character |
| tx_full | output | 1 | Transmit side cannot accept a write |
| tx_empty | output | 1 | Transmit side holds nothing |
| rx_full | output | 1 | Receive side cannot accept a character |
| rx_empty | output | 1 | Receive side holds nothing |

## Verification
The hardest case to reach is the one where a character arrives on a full receive side in the same cycle as a host read. The bench fills all 16 receive entries and then raises `rx_valid` and `rd_en` together. It checks three things: the word read is the oldest entry with overrun still clear, the arriving character is not stored, and the overrun bit shows in the next word. To reach the bypass limit the bench needs a mode change, so the single-entry checks run after `fifo_en` is dropped. That also exercises the flush.

// File: rtl/uart_dataport_pkg.sv
package uart_dataport_pkg;
   localparam int BYTE_W  = 8;
   localparam int WORD_W  = 11;
   localparam int FRM_BIT = 8;
   localparam int PAR_BIT = 9;
   localparam int OVR_BIT = 10;

   // One stored receive character: parity flag, framing flag, data byte
   typedef struct packed {
      logic              perr;
      logic              ferr;
      logic [BYTE_W-1:0] data;
   } rx_entry_t;

   localparam int RX_ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/uart_dp_queue.sv
module uart_dp_queue #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             single,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_dp_queue: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_dp_queue: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             wr_ok, rd_ok;

   // Capacity shrinks to one entry when the bypass holding mode is active
   assign full  = single ? (count != '0) : (count == CAP_FULL);
   assign empty = (count == '0);
   assign wr_ok = push && !full && !flush;
   assign rd_ok = pop && !empty && !flush;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_any
      assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_nxt;
         if (rd_ok) rd_ptr <= rd_nxt;
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout = empty ? '0 : mem[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CAP_FULL);                                               // R2
   AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> $stable(count));            // R5
   AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty);                                      // R7
endmodule

// File: rtl/uart_dp_mode.sv
module uart_dp_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en,
   output logic flush,
   output logic single
);
   logic mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= fifo_en;
   end

   assign flush  = (fifo_en != mode_q);
   assign single = !fifo_en;
endmodule

// File: rtl/uart_dp_overrun.sv
module uart_dp_overrun (
   input  logic clk,
   input  logic rst_n,
   input  logic lost,
   input  logic host_rd,
   output logic ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (lost)    ovr <= 1'b1;
      else if (host_rd) ovr <= 1'b0;
   end

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> ovr);                                                    // R6
   AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !lost) |=> !ovr);                                     // R6
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !host_rd) |=> ovr);                                       // R6
endmodule

// File: rtl/uart_dataport.sv
module uart_dataport
   import uart_dataport_pkg::*;
#(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              rx_empty
);
   localparam int TX_CNT_W = $clog2(TX_DEPTH+1);
   localparam int RX_CNT_W = $clog2(RX_DEPTH+1);

   logic                flush, single, lost, ovr;
   rx_entry_t           rx_in, rx_head;
   logic [TX_CNT_W-1:0] tx_cnt;
   logic [RX_CNT_W-1:0] rx_cnt;

   uart_dp_mode u_mode (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .flush(flush), .single(single)
   );

   uart_dp_queue #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
      .push(wr_en), .din(wr_data), .pop(tx_ready),
      .dout(tx_data), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
   );

   assign rx_in = '{perr: rx_perr, ferr: rx_ferr, data: rx_data};

   uart_dp_queue #(.WIDTH(RX_ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .single(single),
      .push(rx_valid), .din(rx_in), .pop(rd_en),
      .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
   );

   // A character is lost when it meets a full receive side (judged pre-read)
   assign lost = rx_valid && rx_full && !flush;

   uart_dp_overrun u_ovr (
      .clk(clk), .rst_n(rst_n), .lost(lost), .host_rd(rd_en), .ovr(ovr)
   );

   assign tx_valid = !tx_empty;
   assign rd_data  = {ovr, rx_head};

   AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_full && !flush) |=> !tx_empty);                     // R1
   AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_full && !flush) |=> !rx_empty);                  // R4
   AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> (rd_data[PAR_BIT:0] == '0));                         // R7
   AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en)) |-> (tx_cnt <= 1 && rx_cnt <= 1));  // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tx_empty && rx_empty));                                // R10
endmodule

// File: tb/uart_dataport_bench.sv
`timescale 1ns/1ps
module uart_dataport_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fifo_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [10:0] rd_data;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_perr = 1'b0;
   logic        rx_ferr = 1'b0;
   logic        tx_full, tx_empty, rx_full, rx_empty;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   uart_dataport u_uart_dataport (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
      .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic host_write(input logic [7:0] b);
      wr_en = 1'b1; wr_data = b;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] d, input logic p, input logic f);
      rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f;
      tick();
      rx_valid = 1'b0;
   endtask

   task automatic host_read(output logic [10:0] w);
      w = rd_data;
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic tx_take(output logic [7:0] b);
      b = tx_valid ? tx_data : 8'hXX;
      tx_ready = 1'b1;
      tick();
      tx_ready = 1'b0;
   endtask

   function automatic logic [10:0] word_of(input logic o, input logic p,
                                           input logic f, input logic [7:0] d);
      return {o, p, f, d};
   endfunction

   task automatic t_reset();
      check("R11 tx_empty", tx_empty, 1);
      check("R11 rx_empty", rx_empty, 1);
      check("R11 tx_valid", tx_valid, 0);
      check("R11 rd_data", rd_data, 0);
   endtask

   task automatic t_tx_fifo();
      logic [7:0] b;
      for (int i = 0; i < 15; i++) host_write(8'h10 + 8'(i));
      check("R2 not full at 15", tx_full, 0);
      host_write(8'h1F);
      check("R2 full at 16", tx_full, 1);
      check("R1 tx_valid", tx_valid, 1);
      host_write(8'hFF);
      for (int i = 0; i < 16; i++) begin
         tx_take(b);
         check("R1 tx order", b, 8'h10 + 8'(i));
      end
      check("R2 extra write dropped", tx_empty, 1);
   endtask

   task automatic t_rx_basic();
      logic [10:0] w;
      rx_send(8'h3C, 1, 0);
      rx_send(8'hC3, 0, 1);
      rx_send(8'h00, 1, 1);
      check("R4 rx not empty", rx_empty, 0);
      host_read(w); check("R3 word 0", w, 11'h23C);
      host_read(w); check("R3 word 1", w, 11'h1C3);
      host_read(w); check("R3 word 2", w, 11'h300);
      check("R4 rx empty after reads", rx_empty, 1);
   endtask

   task automatic fill_rx();
      for (int i = 0; i < 16; i++) rx_send(8'(i * 7), i[0], i[1]);
   endtask

   task automatic t_rx_overrun();
      logic [10:0] w;
      fill_rx();
      check("R4 rx full at 16", rx_full, 1);
      check("R6 no overrun yet", rd_data[10], 0);
      rx_send(8'hEE, 1, 1);
      check("R6 overrun set", rd_data[10], 1);
      for (int i = 0; i < 16; i++) begin
         host_read(w);
         check("R5 stored entries kept", w,
               word_of(i == 0, i[0], i[1], 8'(i * 7)));
      end
      check("R5 dropped char not stored", rx_empty, 1);
      check("R6 overrun cleared by read", rd_data[10], 0);
      // arrival on full side in the same cycle as a read
      fill_rx();
      rx_valid = 1'b1; rx_data = 8'hEE; rx_perr = 1'b0; rx_ferr = 1'b0;
      host_read(w);
      rx_valid = 1'b0;
      check("R6 same-cycle word", w, word_of(0, 0, 0, 8'h00));
      check("R6 set wins over clear", rd_data[10], 1);
      for (int i = 1; i < 16; i++) begin
         host_read(w);
         check("R5 entries after same-cycle", w,
               word_of(i == 1, i[0], i[1], 8'(i * 7)));
      end
      check("R5 same-cycle char dropped", rx_empty, 1);
   endtask

   task automatic t_empty_read();
      logic [10:0] w;
      host_read(w);
      check("R7 empty read zero", w, 0);
      host_read(w);
      check("R7 second empty read zero", w, 0);
      rx_send(8'hA5, 0, 0);
      host_read(w);
      check("R7 pointers unmoved", w, 11'h0A5);
      check("R7 empty again", rx_empty, 1);
   endtask

   task automatic t_flush();
      for (int i = 0; i < 3; i++) host_write(8'h40 + 8'(i));
      rx_send(8'h11, 0, 0);
      rx_send(8'h22, 0, 0);
      check("R10 tx loaded", tx_empty, 0);
      check("R10 rx loaded", rx_empty, 0);
      fifo_en = 1'b0;
      tick();
      check("R10 tx flushed", tx_empty, 1);
      check("R10 rx flushed", rx_empty, 1);
   endtask

   task automatic t_bypass();
      logic [7:0]  b;
      logic [10:0] w;
      host_write(8'h5A);
      check("R8 tx full at 1", tx_full, 1);
      host_write(8'h33);
      tx_take(b);
      check("R8 holding byte", b, 8'h5A);
      check("R8 second write dropped", tx_empty, 1);
      rx_send(8'h77, 0, 1);
      check("R9 rx full at 1", rx_full, 1);
      rx_send(8'h88, 1, 0);
      host_read(w);
      check("R9 buffer kept with overrun", w, 11'h577);
      check("R9 second char discarded", rx_empty, 1);
      check("R9 overrun cleared", rd_data, 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick(); tick();
      t_reset();
      t_tx_fifo();
      t_rx_basic();
      t_rx_overrun();
      t_empty_read();
      t_flush();
      t_bypass();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule